// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block keeps the tap counts for a bank of six lanes. Each lane has an input-delay counter and an output-delay counter, both nine bits wide. A per-lane select bit chooses which of the two counters a command targets. The same bit chooses which counter is shown on the read-back bus. Each lane takes a three-bit command {load, enable, increment}, which can hold the count, step it by one tap, load it from the lane's field of a packed value bus, or add that field to it as a signed offset.

After reset a sequencer steps through `CT_RESET`, then `CT_CALIB`, then `CT_READY`. In `CT_CALIB` each lane adds its calibration offset to the input-delay counter. The ready output rises when the sequencer enters `CT_READY`, and commands are accepted only from then on. Each delay line has its own lockout machine with two states, `LK_OPEN` and `LK_BUSY`. An accepted update moves it from `LK_OPEN` to `LK_BUSY`. It returns to `LK_OPEN` once the hold time has passed. An update that arrives while the machine is in `LK_BUSY` is dropped and flagged. The applied-tap buses follow the counters one cycle late, which models the applied delay trailing the reported value.

Top module: `tap_delay_ctrl`

## Requirements
- R1: Commands 000 and 001 ({load,enable,increment}) leave the targeted count unchanged.
- R2: Command 010 lowers the count by one and command 011 raises it by one. The count saturates at 0 and at 511.
- R3: Commands 100 and 101 set the count to the lane's 9-bit field. That value is the total count, with no calibration offset added on top.
- R4: Command 111 adds the lane's field to the count, reading the field as a two's-complement value from -256 to 255. A result outside 0..511 clamps to the nearer limit.
- R5: Command 110 leaves the count unchanged and raises that lane's error output for one cycle, starting the cycle after the command.
- R6: Lane k uses bits [9k+8:9k] of the value bus, the read-back bus and both applied buses. A command on one lane never changes another lane.
- R7: Select bit 0 targets and reports the input-delay counter, and select bit 1 targets and reports the output-delay counter. The read-back value is updated at the clock edge that accepts the command.
- R8: The ready output is 0 during reset and in the first cycle after reset is released, and it is 1 from the second cycle on. Any command given while ready is 0 is ignored.
- R9: An accepted update (010, 011, 100, 101 or 111) blocks further updates to the same line for the next two cycles, so a new update is accepted three cycles after the previous one. The other line of the lane and all other lanes are not blocked.
- R10: A blocked update leaves the count unchanged and raises that lane's violation output for one cycle, starting the cycle after the command. Holds and 110 are not updates: they neither start the lockout nor raise a violation.
- R11: Each applied-tap bus shows its counter's value one cycle later than the counter changes.
- R12: At reset both counters hold INIT_TAPS (default 100). When the calibration-enable input is 1, the input-delay counter then gains the lane's calibration offset, saturating at 511. The output-delay counter never gains the offset, and the input-delay counter does not gain it when calibration-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_en_i | input | 1 | Adds the calibration offset to the input delays |
| cal_ofs_i | input | 54 | Per-lane calibration offsets, 9 bits per lane |
| sel_i | input | 6 | Per-lane line select: 0 selects the input delay, 1 the output delay |
| ld_i | input | 6 | Per-lane load bit of the command |
| en_i | input | 6 | Per-lane enable bit of the command |
| inc_i | input | 6 | Per-lane increment bit of the command |
| val_i | input | 54 | Per-lane tap value for load or add |
| dly_rdy_o | output | 1 | Ready; commands are accepted only while this is 1 |
| rd_taps_o | output | 54 | Reported count of the selected line for each lane |
| app_in_o | output | 54 | Applied input-delay taps for each lane |
| app_out_o | output | 54 | Applied output-delay taps for each lane |
| viol_o | output | 6 | One-cycle pulse for a blocked update |
| err_o | output | 6 | One-cycle pulse for the unsupported command |

## Verification
Each fault in the internal state appears at the ports within one or two cycles. If a lockout machine is stuck in `LK_OPEN`, an update issued one or two cycles after the previous one changes the read-back value and no violation pulse follows. If the machine is stuck in `LK_BUSY`, the read-back value stays frozen and violation pulses keep arriving. If the sequencer is wrong, the ready output rises at the wrong time, or the input-delay read-back differs from the initial value plus the calibration offset. A fault in the arithmetic shows on the read-back bus at the first saturating step or clamped add.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        CT_RESET,
        CT_CALIB,
        CT_READY
    } ctl_st_t;

    typedef enum logic {
        LK_OPEN,
        LK_BUSY
    } lock_st_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_DEC,
        OP_INC,
        OP_LOAD,
        OP_BAD,
        OP_ADD
    } tap_op_t;

    function automatic tap_op_t decode_cmd(input logic [2:0] cmd);
        tap_op_t op;
        unique case (cmd)
            3'b000, 3'b001: op = OP_HOLD;
            3'b010:         op = OP_DEC;
            3'b011:         op = OP_INC;
            3'b100, 3'b101: op = OP_LOAD;
            3'b110:         op = OP_BAD;
            default:        op = OP_ADD;
        endcase
        return op;
    endfunction

    function automatic logic is_update(input tap_op_t op);
        return (op == OP_DEC) || (op == OP_INC) || (op == OP_LOAD) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/tdc_tap_calc.sv
module tdc_tap_calc
    import tdc_pkg::*;
#(
    parameter int TAP_W = 9
) (
    input  tap_op_t          op_i,
    input  logic [TAP_W-1:0] cur_i,
    input  logic [TAP_W-1:0] fld_i,
    output logic [TAP_W-1:0] nxt_o
);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    logic signed [TAP_W+1:0] sum;

    always_comb begin
        sum = $signed({2'b00, cur_i}) + $signed({{2{fld_i[TAP_W-1]}}, fld_i});
    end

    always_comb begin
        unique case (op_i)
            OP_DEC:  nxt_o = (cur_i == '0) ? '0 : cur_i - 1'b1;
            OP_INC:  nxt_o = (cur_i == TAP_MAX) ? TAP_MAX : cur_i + 1'b1;
            OP_LOAD: nxt_o = fld_i;
            OP_ADD: begin
                if (sum < 0)
                    nxt_o = '0;
                else if (sum > $signed({2'b00, TAP_MAX}))
                    nxt_o = TAP_MAX;
                else
                    nxt_o = sum[TAP_W-1:0];
            end
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/tdc_lockout.sv
module tdc_lockout
    import tdc_pkg::*;
#(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic open_o
);
    localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 2);

    lock_st_t        st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LK_OPEN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            LK_OPEN: begin
                if (req_i) begin
                    st_d  = LK_BUSY;
                    cnt_d = RELOAD;
                end
            end
            LK_BUSY: begin
                if (cnt_q == '0)
                    st_d = LK_OPEN;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            default: st_d = LK_OPEN;
        endcase
    end

    always_comb begin
        open_o = (st_q == LK_OPEN);
    end
endmodule

// File: rtl/tdc_lane.sv
module tdc_lane
    import tdc_pkg::*;
#(
    parameter int TAP_W     = 9,
    parameter int HOLD_CYC  = 3,
    parameter int INIT_TAPS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_i,
    input  logic             calib_i,
    input  logic             cal_en_i,
    input  logic [TAP_W-1:0] cal_ofs_i,
    input  logic             sel_i,
    input  logic [2:0]       cmd_i,
    input  logic [TAP_W-1:0] val_i,
    output logic [TAP_W-1:0] rd_o,
    output logic [TAP_W-1:0] app_in_o,
    output logic [TAP_W-1:0] app_out_o,
    output logic             viol_o,
    output logic             err_o
);
    localparam int NLINE = 2;
    localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] INIT_VAL = TAP_W'(INIT_TAPS);

    tap_op_t                      op;
    logic                         upd;
    logic [NLINE-1:0][TAP_W-1:0]  cnt_w;
    logic [NLINE-1:0][TAP_W-1:0]  app_q;
    logic [NLINE-1:0]             reject;
    logic [TAP_W-1:0]             cur;
    logic [TAP_W-1:0]             nxt;

    always_comb begin
        op  = decode_cmd(cmd_i);
        upd = ready_i && is_update(op);
        cur = cnt_w[sel_i];
    end

    tdc_tap_calc #(.TAP_W(TAP_W)) u_calc (
        .op_i  (op),
        .cur_i (cur),
        .fld_i (val_i),
        .nxt_o (nxt)
    );

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic             req;
        logic             open;
        logic [TAP_W-1:0] cnt_q;

        assign req = upd && (sel_i == l[0]);

        tdc_lockout #(.HOLD_CYC(HOLD_CYC)) u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req),
            .open_o (open)
        );

        if (l == 0) begin : g_cal
            logic [TAP_W:0] cal_sum;
            assign cal_sum = {1'b0, cnt_q} + {1'b0, cal_ofs_i};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= INIT_VAL;
                else if (calib_i && cal_en_i)
                    cnt_q <= cal_sum[TAP_W] ? TAP_MAX : cal_sum[TAP_W-1:0];
                else if (req && open)
                    cnt_q <= nxt;
            end
        end else begin : g_nocal
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= INIT_VAL;
                else if (req && open)
                    cnt_q <= nxt;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                app_q[l] <= INIT_VAL;
            else
                app_q[l] <= cnt_q;
        end

        assign cnt_w[l]  = cnt_q;
        assign reject[l] = req && !open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            viol_o <= |reject;
            err_o  <= ready_i && (op == OP_BAD);
        end
    end

    always_comb begin
        rd_o      = cnt_w[sel_i];
        app_in_o  = app_q[0];
        app_out_o = app_q[1];
    end
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
    import tdc_pkg::*;
#(
    parameter int LANES     = 6,
    parameter int TAP_W     = 9,
    parameter int HOLD_CYC  = 3,
    parameter int INIT_TAPS = 100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cal_en_i,
    input  logic [LANES*TAP_W-1:0] cal_ofs_i,
    input  logic [LANES-1:0]       sel_i,
    input  logic [LANES-1:0]       ld_i,
    input  logic [LANES-1:0]       en_i,
    input  logic [LANES-1:0]       inc_i,
    input  logic [LANES*TAP_W-1:0] val_i,
    output logic                   dly_rdy_o,
    output logic [LANES*TAP_W-1:0] rd_taps_o,
    output logic [LANES*TAP_W-1:0] app_in_o,
    output logic [LANES*TAP_W-1:0] app_out_o,
    output logic [LANES-1:0]       viol_o,
    output logic [LANES-1:0]       err_o
);
    ctl_st_t st_q, st_d;
    logic    ready;
    logic    calib;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= CT_RESET;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CT_RESET: st_d = CT_CALIB;
            CT_CALIB: st_d = CT_READY;
            CT_READY: st_d = CT_READY;
            default:  st_d = CT_RESET;
        endcase
    end

    always_comb begin
        ready     = (st_q == CT_READY);
        calib     = (st_q == CT_CALIB);
        dly_rdy_o = ready;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tdc_lane #(
            .TAP_W     (TAP_W),
            .HOLD_CYC  (HOLD_CYC),
            .INIT_TAPS (INIT_TAPS)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ready_i   (ready),
            .calib_i   (calib),
            .cal_en_i  (cal_en_i),
            .cal_ofs_i (cal_ofs_i[k*TAP_W +: TAP_W]),
            .sel_i     (sel_i[k]),
            .cmd_i     ({ld_i[k], en_i[k], inc_i[k]}),
            .val_i     (val_i[k*TAP_W +: TAP_W]),
            .rd_o      (rd_taps_o[k*TAP_W +: TAP_W]),
            .app_in_o  (app_in_o[k*TAP_W +: TAP_W]),
            .app_out_o (app_out_o[k*TAP_W +: TAP_W]),
            .viol_o    (viol_o[k]),
            .err_o     (err_o[k])
        );
    end
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
    parameter int LANES = 6,
    parameter int TAP_W = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       sel_i,
    input logic [LANES-1:0]       ld_i,
    input logic [LANES-1:0]       en_i,
    input logic [LANES-1:0]       inc_i,
    input logic                   dly_rdy_o,
    input logic [LANES*TAP_W-1:0] rd_taps_o,
    input logic [LANES*TAP_W-1:0] app_in_o,
    input logic [LANES*TAP_W-1:0] app_out_o,
    input logic [LANES-1:0]       viol_o,
    input logic [LANES-1:0]       err_o
);
    // R8
    quiet_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_rdy_o |=> (viol_o == '0) && (err_o == '0));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R5
        err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[k] |-> $past(dly_rdy_o) && $past(ld_i[k] && en_i[k] && !inc_i[k]));

        // R10
        viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            viol_o[k] |-> $past(dly_rdy_o) && $past(ld_i[k] || en_i[k]) && !err_o[k]);

        // R11
        app_in_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dly_rdy_o) && !$past(sel_i[k])) |->
                app_in_o[k*TAP_W +: TAP_W] == $past(rd_taps_o[k*TAP_W +: TAP_W]));

        // R11
        app_out_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dly_rdy_o) && $past(sel_i[k])) |->
                app_out_o[k*TAP_W +: TAP_W] == $past(rd_taps_o[k*TAP_W +: TAP_W]));

        // R1
        hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dly_rdy_o) && $past(!ld_i[k] && !en_i[k]) && ($past(sel_i[k]) == sel_i[k])) |->
                rd_taps_o[k*TAP_W +: TAP_W] == $past(rd_taps_o[k*TAP_W +: TAP_W]));
    end
endmodule

bind tap_delay_ctrl tdc_checker #(.LANES(LANES), .TAP_W(TAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .ld_i      (ld_i),
    .en_i      (en_i),
    .inc_i     (inc_i),
    .dly_rdy_o (dly_rdy_o),
    .rd_taps_o (rd_taps_o),
    .app_in_o  (app_in_o),
    .app_out_o (app_out_o),
    .viol_o    (viol_o),
    .err_o     (err_o)
);

// File: tb/sim_tap_delay_ctrl.sv
`timescale 1ns/1ps
module sim_tap_delay_ctrl;
    localparam int L = 6;
    localparam int W = 9;
    localparam int NV = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cal_en;
    logic [L*W-1:0] cal_ofs;
    logic [L-1:0]   sel, ld, en, inc;
    logic [L*W-1:0] val;
    logic           rdy;
    logic [L*W-1:0] rd, app_in, app_out;
    logic [L-1:0]   viol, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    tap_delay_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cal_en_i(cal_en), .cal_ofs_i(cal_ofs),
        .sel_i(sel), .ld_i(ld), .en_i(en), .inc_i(inc), .val_i(val),
        .dly_rdy_o(rdy), .rd_taps_o(rd), .app_in_o(app_in), .app_out_o(app_out),
        .viol_o(viol), .err_o(err)
    );

    // {sel, cmd[2:0], val[8:0], exp[8:0], viol, err} applied to lane 2
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 3'b100, 9'd50,  9'd50,  1'b0, 1'b0},
        {1'b0, 3'b011, 9'd0,   9'd50,  1'b1, 1'b0},
        {1'b1, 3'b011, 9'd0,   9'd101, 1'b0, 1'b0},
        {1'b0, 3'b011, 9'd0,   9'd51,  1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd51,  1'b0, 1'b0},
        {1'b0, 3'b001, 9'd0,   9'd51,  1'b0, 1'b0},
        {1'b0, 3'b010, 9'd0,   9'd50,  1'b0, 1'b0},
        {1'b1, 3'b000, 9'd0,   9'd101, 1'b0, 1'b0},
        {1'b1, 3'b000, 9'd0,   9'd101, 1'b0, 1'b0},
        {1'b0, 3'b111, 9'h1F6, 9'd40,  1'b0, 1'b0},
        {1'b0, 3'b010, 9'd0,   9'd40,  1'b1, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd40,  1'b0, 1'b0},
        {1'b0, 3'b101, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b010, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b111, 9'h1F0, 9'd0,   1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd0,   1'b0, 1'b0},
        {1'b0, 3'b100, 9'd511, 9'd511, 1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd511, 1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd511, 1'b0, 1'b0},
        {1'b0, 3'b011, 9'd0,   9'd511, 1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd511, 1'b0, 1'b0},
        {1'b0, 3'b000, 9'd0,   9'd511, 1'b0, 1'b0},
        {1'b0, 3'b111, 9'd5,   9'd511, 1'b0, 1'b0},
        {1'b0, 3'b110, 9'd0,   9'd511, 1'b0, 1'b1},
        {1'b0, 3'b111, 9'd3,   9'd511, 1'b1, 1'b0},
        {1'b1, 3'b111, 9'h0FF, 9'd356, 1'b0, 1'b0},
        {1'b1, 3'b000, 9'd0,   9'd356, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane(input logic [L*W-1:0] bus, input int k);
        return int'(bus[k*W +: W]);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_cmd();
        ld = '0; en = '0; inc = '0; val = '0;
    endtask

    task automatic set_cmd(input int k, input logic [2:0] c, input int v);
        ld[k] = c[2]; en[k] = c[1]; inc[k] = c[0];
        val[k*W +: W] = W'(v);
    endtask

    task automatic do_reset(input logic ce);
        rst_n = 1'b0;
        cal_en = ce;
        sel = '0;
        idle_cmd();
        tick();
        tick();
    endtask

    initial begin
        cal_ofs = {9'd15, 9'd14, 9'd450, 9'd12, 9'd11, 9'd10};
        do_reset(1'b1);
        chk("R8 ready low in reset", int'(rdy), 0);
        chk("R12 reset input count", lane(rd, 1), 100);
        // commands during sequencing must be ignored
        set_cmd(1, 3'b100, 7);
        rst_n = 1'b1;
        tick();
        chk("R8 ready low first cycle", int'(rdy), 0);
        tick();
        chk("R8 ready high second cycle", int'(rdy), 1);
        idle_cmd();
        chk("R8 early load ignored / R12 offset", lane(rd, 1), 111);
        chk("R12 offset saturates", lane(rd, 3), 511);
        sel = 6'b000001;
        #0;
        #1;
        chk("R12 output has no offset", lane(rd, 0), 100);
        sel = '0;
        tick();

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            sel[2] = v[23];
            set_cmd(2, v[22:20], int'(v[19:11]));
            tick();
            chk($sformatf("R1-table R2 R3 R4 R7 R9 vec%0d rd", i), lane(rd, 2), int'(v[10:2]));
            chk($sformatf("R10 vec%0d viol", i), int'(viol), int'(v[1]) << 2);
            chk($sformatf("R5 vec%0d err", i), int'(err), int'(v[0]) << 2);
            idle_cmd();
        end

        // R6: other lanes untouched by lane 2 traffic
        sel = '0;
        #1;
        chk("R6 lane0 untouched", lane(rd, 0), 110);
        chk("R6 lane5 untouched", lane(rd, 5), 115);
        chk("R6 lane2 applied output", lane(app_out, 2), 356);

        // R11 applied lag
        set_cmd(2, 3'b100, 77);
        tick();
        idle_cmd();
        chk("R11 reported leads", lane(rd, 2), 77);
        chk("R11 applied old", lane(app_in, 2), 511);
        tick();
        chk("R11 applied new", lane(app_in, 2), 77);

        // R6: simultaneous lanes
        set_cmd(0, 3'b100, 200);
        set_cmd(4, 3'b100, 300);
        tick();
        idle_cmd();
        chk("R6 lane0 load", lane(rd, 0), 200);
        chk("R6 lane4 load", lane(rd, 4), 300);
        chk("R6 lane1 unchanged", lane(rd, 1), 111);

        // R12 without calibration
        do_reset(1'b0);
        rst_n = 1'b1;
        tick();
        tick();
        chk("R12 no offset when disabled", lane(rd, 1), 100);
        chk("R8 ready after second reset", int'(rdy), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule